// File: doc/BRIEF.md
# Programmable Local Bus Cycle Sequencer

This block turns one accepted host access into a single 8-bit peripheral bus cycle. Every strobe edge and every change of data-bus direction sits at a programmable offset, counted in host clocks from a reference cycle. The reference cycle falls two clocks after the clock edge that samples the host start strobe. Seven 4-bit timing fields set these offsets: chip-select on and off, strobe on and off, the start and end of a read release window, and an idle-drive field. A style bit picks one of two control schemes. In the first, separate read and write strobes are used. In the second, a single data strobe works together with a read-not-write direction line.

A timing set that is out of range, or whose chip-select ordering makes no sense, does not run a cycle. The block answers it with a one-clock retry pulse. A normal cycle ends with a one-clock done pulse, and for a read the captured byte is held on the read-data output. The block also passes through a software-controlled peripheral reset and a gated copy of the host clock.

Top module: `pbs_lbus_seq`

## Requirements
- R1: `req_start` is sampled at a clock edge when idle. The address, and for a write the write data, appear on `pb_addr`/`pb_dout` two edges later. That cycle is offset 0, and every offset below counts from it.
- R2: `pb_cs` is high exactly at offsets t with `t_cs_on <= t < t_cs_off`.
- R3: With `bus_style`=0, the strobe is active at offsets t with `t_stb_on <= t < t_stb_off`. `pb_rd` carries it for reads and `pb_wr` for writes. `pb_dstb` stays 0 and `pb_rnw` stays 1.
- R4: With `bus_style`=1, `pb_dstb` carries that strobe window for reads and writes alike, and `pb_rd`/`pb_wr` stay 0. For a write, `pb_rnw` is 0 from offset 0 through the cycle's last programmed offset. For a read it stays 1.
- R5: When `t_idle`=15, `pb_doe` is 1 while idle and during writes. During a read it is 0 only at offsets t with `t_rd_rel <= t < t_rd_drv`.
- R6: When `t_idle` is 0..10, `pb_doe` is 0 while idle and during reads. During a write it is 1 at offsets t < `t_idle`. `t_rd_rel`/`t_rd_drv` are then ignored, and values above 10 in them cause no retry.
- R7: The cycle is refused if any of these holds: an in-use offset field exceeds 10, or `t_idle` is 11..14. Refused means `req_retry` pulses high for the one cycle after the start edge and no strobe, select or done follows.
- R8: The cycle is also refused with a `req_retry` pulse if `t_cs_on` > `t_cs_off` or `t_cs_on` > `t_stb_on`.
- R9: For reads, `pb_din` is sampled at the edge that produces offset `t_stb_off` and held on `req_rdata`.
- R10: The last programmed offset L is the largest of: `t_cs_off`, `t_stb_off`, `t_idle` for a write with `t_idle` < 15, and `t_rd_drv` for a read with `t_idle`=15. `req_done` is high for one cycle at offset L+1. A start sampled while a cycle is in progress is ignored. A start sampled after the done cycle is accepted.
- R11: `pb_rst` follows `sw_reset` one clock later. `pb_clk` is the host clock while the registered `clk_enable` is 1 and is held low otherwise.
- R12: After synchronous reset, select, strobes, done and retry are 0, `pb_rnw` is 1 and `pb_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Host transaction start strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| t_cs_on | input | 4 | Chip-select assert offset |
| t_cs_off | input | 4 | Chip-select deassert offset |
| t_stb_on | input | 4 | Strobe assert offset |
| t_stb_off | input | 4 | Strobe deassert offset |
| t_rd_rel | input | 4 | Read: data bus release offset |
| t_rd_drv | input | 4 | Read: data bus re-drive offset |
| t_idle | input | 4 | Idle-drive field (15 = keep driven) |
| bus_style | input | 1 | 0 = split strobes, 1 = strobe plus direction |
| sw_reset | input | 1 | Software peripheral reset bit |
| clk_enable | input | 1 | Peripheral clock enable bit |
| pb_din | input | DATA_W | Peripheral read data |
| pb_addr | output | ADDR_W | Peripheral address |
| pb_cs | output | 1 | Chip select (active high) |
| pb_rd | output | 1 | Read strobe (active high) |
| pb_wr | output | 1 | Write strobe (active high) |
| pb_dstb | output | 1 | Single data strobe (active high) |
| pb_rnw | output | 1 | Direction line, 0 = write |
| pb_dout | output | DATA_W | Peripheral write data |
| pb_doe | output | 1 | Data bus output enable |
| pb_rst | output | 1 | Peripheral reset |
| pb_clk | output | 1 | Gated peripheral clock |
| req_rdata | output | DATA_W | Captured read data |
| req_done | output | 1 | Cycle complete pulse |
| req_retry | output | 1 | Refused cycle pulse |

## Verification
Two events can share a cycle: a cycle completing (the done pulse with all controls returning idle) and the host asking for the next access. The bench raises `req_start` inside the done cycle itself, so the new request is sampled at the very next edge. It also pulses a second start a few cycles into a running access. The reference model accepts the first request and ignores the second. On every clock it checks that the new reference cycle starts exactly two edges after the done cycle and that the intrusive start never disturbs the running strobes.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int OFS_W     = 4;
  localparam int MAX_OFS   = 10;
  localparam int IDLE_KEEP = (1 << OFS_W) - 1;
  localparam int NUM_WIN   = 3;

  typedef struct packed {
    logic [OFS_W-1:0] cs_on;
    logic [OFS_W-1:0] cs_off;
    logic [OFS_W-1:0] stb_on;
    logic [OFS_W-1:0] stb_off;
    logic [OFS_W-1:0] rd_rel;
    logic [OFS_W-1:0] rd_drv;
    logic [OFS_W-1:0] idle;
    logic             style;
  } pbs_cfg_t;
endpackage

// File: rtl/pbs_cfg_check.sv
module pbs_cfg_check
  import pbs_pkg::*;
(
  input  pbs_cfg_t         cfg,
  input  logic             is_wr,
  output logic             range_err,
  output logic             order_err,
  output logic [OFS_W-1:0] last_ofs
);
  logic keep;
  logic [OFS_W-1:0] a, b;

  assign keep = (cfg.idle == OFS_W'(IDLE_KEEP));

  always_comb begin
    range_err = (cfg.cs_on  > OFS_W'(MAX_OFS)) || (cfg.cs_off  > OFS_W'(MAX_OFS)) ||
                (cfg.stb_on > OFS_W'(MAX_OFS)) || (cfg.stb_off > OFS_W'(MAX_OFS)) ||
                (!keep && (cfg.idle > OFS_W'(MAX_OFS))) ||
                (keep && ((cfg.rd_rel > OFS_W'(MAX_OFS)) || (cfg.rd_drv > OFS_W'(MAX_OFS))));
    order_err = (cfg.cs_on > cfg.cs_off) || (cfg.cs_on > cfg.stb_on);
  end

  always_comb begin
    a = (cfg.cs_off > cfg.stb_off) ? cfg.cs_off : cfg.stb_off;
    if (is_wr && !keep)      b = cfg.idle;
    else if (!is_wr && keep) b = cfg.rd_drv;
    else                     b = '0;
    last_ofs = (a > b) ? a : b;
  end
endmodule

// File: rtl/pbs_window.sv
module pbs_window #(
  parameter int W = 4
) (
  input  logic [W-1:0] t,
  input  logic [W-1:0] on_ofs,
  input  logic [W-1:0] off_ofs,
  output logic         active
);
  assign active = (t >= on_ofs) && (t < off_ofs);
endmodule

// File: rtl/pbs_lbus_seq.sv
module pbs_lbus_seq
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [3:0]        t_cs_on,
  input  logic [3:0]        t_cs_off,
  input  logic [3:0]        t_stb_on,
  input  logic [3:0]        t_stb_off,
  input  logic [3:0]        t_rd_rel,
  input  logic [3:0]        t_rd_drv,
  input  logic [3:0]        t_idle,
  input  logic              bus_style,
  input  logic              sw_reset,
  input  logic              clk_enable,
  input  logic [DATA_W-1:0] pb_din,
  output logic [ADDR_W-1:0] pb_addr,
  output logic              pb_cs,
  output logic              pb_rd,
  output logic              pb_wr,
  output logic              pb_dstb,
  output logic              pb_rnw,
  output logic [DATA_W-1:0] pb_dout,
  output logic              pb_doe,
  output logic              pb_rst,
  output logic              pb_clk,
  output logic [DATA_W-1:0] req_rdata,
  output logic              req_done,
  output logic              req_retry
);
  typedef enum logic [1:0] {S_IDLE, S_PRE1, S_PRE2, S_ACT} st_t;

  st_t              state;
  pbs_cfg_t         cfg_in, cfg_q;
  logic             wr_q, clk_en_q, keep_q, idle_drive;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [OFS_W-1:0] t_q, end_q, nt, last_ofs;
  logic             range_err, order_err;
  logic [NUM_WIN-1:0][OFS_W-1:0] w_on, w_off;
  logic [NUM_WIN-1:0] w_act;
  logic             doe_next;

  assign cfg_in = '{cs_on: t_cs_on, cs_off: t_cs_off, stb_on: t_stb_on,
                    stb_off: t_stb_off, rd_rel: t_rd_rel, rd_drv: t_rd_drv,
                    idle: t_idle, style: bus_style};

  pbs_cfg_check u_cfg_check (
    .cfg       (cfg_in),
    .is_wr     (req_wr),
    .range_err (range_err),
    .order_err (order_err),
    .last_ofs  (last_ofs)
  );

  // offset the registered outputs will show after this edge
  assign nt = (state == S_PRE2) ? '0 : t_q + 1'b1;

  assign w_on  = {cfg_q.rd_rel, cfg_q.stb_on,  cfg_q.cs_on};
  assign w_off = {cfg_q.rd_drv, cfg_q.stb_off, cfg_q.cs_off};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    pbs_window #(.W(OFS_W)) u_win (
      .t       (nt),
      .on_ofs  (w_on[i]),
      .off_ofs (w_off[i]),
      .active  (w_act[i])
    );
  end

  assign keep_q     = (cfg_q.idle == OFS_W'(IDLE_KEEP));
  assign idle_drive = (t_idle == 4'(IDLE_KEEP));

  always_comb begin
    if (keep_q) doe_next = wr_q ? 1'b1 : !w_act[2];
    else        doe_next = wr_q && (nt < cfg_q.idle);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cfg_q     <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      t_q       <= '0;
      end_q     <= '0;
      pb_addr   <= '0;
      pb_cs     <= 1'b0;
      pb_rd     <= 1'b0;
      pb_wr     <= 1'b0;
      pb_dstb   <= 1'b0;
      pb_rnw    <= 1'b1;
      pb_dout   <= '0;
      pb_doe    <= 1'b0;
      pb_rst    <= 1'b0;
      clk_en_q  <= 1'b0;
      req_rdata <= '0;
      req_done  <= 1'b0;
      req_retry <= 1'b0;
    end else begin
      req_done  <= 1'b0;
      req_retry <= 1'b0;
      pb_rst    <= sw_reset;
      clk_en_q  <= clk_enable;
      case (state)
        S_IDLE: begin
          pb_doe <= idle_drive;
          if (req_start) begin
            if (range_err || order_err) begin
              req_retry <= 1'b1;
            end else begin
              cfg_q   <= cfg_in;
              wr_q    <= req_wr;
              addr_q  <= req_addr;
              wdata_q <= req_wdata;
              end_q   <= last_ofs;
              state   <= S_PRE1;
            end
          end
        end
        S_PRE1: begin
          pb_doe <= idle_drive;
          state  <= S_PRE2;
        end
        default: begin
          t_q     <= nt;
          pb_cs   <= w_act[0];
          pb_rd   <= !cfg_q.style && !wr_q && w_act[1];
          pb_wr   <= !cfg_q.style &&  wr_q && w_act[1];
          pb_dstb <= cfg_q.style && w_act[1];
          pb_rnw  <= !(cfg_q.style && wr_q) || (nt > end_q);
          pb_doe  <= doe_next;
          if (nt == '0) begin
            pb_addr <= addr_q;
            if (wr_q) pb_dout <= wdata_q;
          end
          if (!wr_q && (nt == cfg_q.stb_off)) req_rdata <= pb_din;
          if (nt == end_q + 1'b1) begin
            req_done <= 1'b1;
            state    <= S_IDLE;
          end else begin
            state    <= S_ACT;
          end
        end
      endcase
    end
  end

  assign pb_clk = clk & clk_en_q;
endmodule

// File: rtl/pbs_lbus_seq_sva.sv
module pbs_lbus_seq_sva (
  input logic clk,
  input logic rst,
  input logic pb_cs,
  input logic pb_rd,
  input logic pb_wr,
  input logic pb_dstb,
  input logic pb_rnw,
  input logic req_done,
  input logic req_retry,
  input logic sw_reset,
  input logic pb_rst
);
  assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(pb_rd && pb_wr));

  assert_style_excl_R4: assert property (@(posedge clk) disable iff (rst)
    pb_dstb |-> (!pb_rd && !pb_wr));

  assert_retry_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    req_retry |-> (!pb_cs && !pb_rd && !pb_wr && !pb_dstb && !req_done));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  assert_done_released_R2: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (!pb_cs && pb_rnw));

  assert_swrst_on_R11: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> pb_rst);

  assert_swrst_off_R11: assert property (@(posedge clk) disable iff (rst)
    !sw_reset |=> !pb_rst);

  assert_reset_state_R12: assert property (@(posedge clk)
    rst |=> (!pb_cs && !req_done && !req_retry && pb_rnw));
endmodule

bind pbs_lbus_seq pbs_lbus_seq_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .pb_cs     (pb_cs),
  .pb_rd     (pb_rd),
  .pb_wr     (pb_wr),
  .pb_dstb   (pb_dstb),
  .pb_rnw    (pb_rnw),
  .req_done  (req_done),
  .req_retry (req_retry),
  .sw_reset  (sw_reset),
  .pb_rst    (pb_rst)
);

// File: tb/pbs_lbus_seq_bench.sv
`timescale 1ns/1ps
module pbs_lbus_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic req_start = 0, req_wr = 0;
  logic [7:0] req_addr = 0, req_wdata = 0, pb_din = 8'h11;
  logic [3:0] t_cs_on = 0, t_cs_off = 4, t_stb_on = 1, t_stb_off = 3;
  logic [3:0] t_rd_rel = 0, t_rd_drv = 4, t_idle = 15;
  logic bus_style = 0, sw_reset = 0, clk_enable = 0;
  logic [7:0] pb_addr, pb_dout, req_rdata;
  logic pb_cs, pb_rd, pb_wr, pb_dstb, pb_rnw, pb_doe, pb_rst, pb_clk, req_done, req_retry;

  pbs_lbus_seq u_pbs_lbus_seq (.*);

  int vectors = 0, errors = 0;
  bit finished = 0, model_valid = 0;

  // ---------------- reference model ----------------
  logic [7:0] e_addr, e_dout, e_rdata;
  logic e_cs, e_rd, e_wr, e_dstb, e_rnw, e_doe, e_prst, e_clken, e_done, e_retry;
  string retry_tag = "R7";
  bit busy = 0;
  int kk, m_cson, m_csoff, m_son, m_soff, m_rr, m_rd, m_idle, m_end;
  bit m_wr, m_sty;
  logic [7:0] m_addr, m_wd;

  always @(negedge clk) pb_din <= pb_din + 8'd29;

  always @(posedge clk) begin
    if (rst) begin
      busy = 0; e_addr = 0; e_dout = 0; e_rdata = 0; e_cs = 0; e_rd = 0; e_wr = 0;
      e_dstb = 0; e_rnw = 1; e_doe = 0; e_prst = 0; e_clken = 0; e_done = 0; e_retry = 0;
    end else begin
      e_done = 0; e_retry = 0; e_prst = sw_reset; e_clken = clk_enable;
      if (!busy) begin
        e_doe = (t_idle == 15);
        if (req_start) begin
          bit rng, ord;
          rng = (t_cs_on > 10) || (t_cs_off > 10) || (t_stb_on > 10) || (t_stb_off > 10) ||
                (t_idle > 10 && t_idle < 15) ||
                (t_idle == 15 && (t_rd_rel > 10 || t_rd_drv > 10));
          ord = (t_cs_on > t_cs_off) || (t_cs_on > t_stb_on);
          if (rng || ord) begin
            e_retry = 1; retry_tag = rng ? "R7" : "R8";
          end else begin
            busy = 1; kk = -2;
            m_cson = t_cs_on; m_csoff = t_cs_off; m_son = t_stb_on; m_soff = t_stb_off;
            m_rr = t_rd_rel; m_rd = t_rd_drv; m_idle = t_idle; m_sty = bus_style;
            m_wr = req_wr; m_addr = req_addr; m_wd = req_wdata;
            m_end = (m_csoff > m_soff) ? m_csoff : m_soff;
            if (m_wr && m_idle != 15 && m_idle > m_end) m_end = m_idle;
            if (!m_wr && m_idle == 15 && m_rd > m_end) m_end = m_rd;
          end
        end
      end else begin
        kk++;
        if (kk < 0) e_doe = (t_idle == 15);
        else begin
          bit stb;
          if (kk == 0) begin e_addr = m_addr; if (m_wr) e_dout = m_wd; end
          e_cs = (kk >= m_cson) && (kk < m_csoff);
          stb  = (kk >= m_son) && (kk < m_soff);
          e_rd = !m_sty && !m_wr && stb;
          e_wr = !m_sty && m_wr && stb;
          e_dstb = m_sty && stb;
          e_rnw = !(m_sty && m_wr) || (kk > m_end);
          if (m_idle == 15) e_doe = m_wr ? 1'b1 : !((kk >= m_rr) && (kk < m_rd));
          else              e_doe = m_wr && (kk < m_idle);
          if (!m_wr && kk == m_soff) e_rdata = pb_din;
          if (kk == m_end + 1) begin e_done = 1; busy = 0; end
        end
      end
    end
    model_valid = 1;
  end

  task automatic chk(input string tag, input string name, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_valid && !finished) begin
    chk("R1", "pb_addr", pb_addr, e_addr);
    chk("R1", "pb_dout", pb_dout, e_dout);
    chk("R2", "pb_cs", {7'd0, pb_cs}, {7'd0, e_cs});
    chk("R3", "pb_rd", {7'd0, pb_rd}, {7'd0, e_rd});
    chk("R3", "pb_wr", {7'd0, pb_wr}, {7'd0, e_wr});
    chk("R4", "pb_dstb", {7'd0, pb_dstb}, {7'd0, e_dstb});
    chk("R4", "pb_rnw", {7'd0, pb_rnw}, {7'd0, e_rnw});
    chk((t_idle == 15) ? "R5" : "R6", "pb_doe", {7'd0, pb_doe}, {7'd0, e_doe});
    chk(retry_tag, "req_retry", {7'd0, req_retry}, {7'd0, e_retry});
    chk("R9", "req_rdata", req_rdata, e_rdata);
    chk("R10", "req_done", {7'd0, req_done}, {7'd0, e_done});
    chk("R11", "pb_rst", {7'd0, pb_rst}, {7'd0, e_prst});
  end

  initial forever begin
    @(posedge clk); #1;
    if (model_valid && !finished) chk("R11", "pb_clk", {7'd0, pb_clk}, {7'd0, e_clken});
  end

  // ---------------- stimulus ----------------
  task automatic set_t(input int con, coff, son, soff, rr, rd, idl, sty);
    @(negedge clk);
    t_cs_on = 4'(con); t_cs_off = 4'(coff); t_stb_on = 4'(son); t_stb_off = 4'(soff);
    t_rd_rel = 4'(rr); t_rd_drv = 4'(rd); t_idle = 4'(idl); bus_style = sty[0];
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_start = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_start = 0;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: reset state visible before any access
    chk("R12", "reset cs", {7'd0, pb_cs}, 8'd0);
    chk("R12", "reset rnw", {7'd0, pb_rnw}, 8'd1);
    chk("R12", "reset done", {7'd0, req_done}, 8'd0);

    // R1 R2 R3 R5: default timing, split strobes, keep-driven idle
    access(1, 8'h3C, 8'h5A);
    access(0, 8'hC3, 8'h00);
    // R4: single strobe plus direction line
    set_t(0, 4, 1, 3, 0, 4, 15, 1);
    access(1, 8'h12, 8'hE7);
    access(0, 8'h34, 8'h00);
    // R6: float idle, read window fields out of range are ignored
    set_t(0, 4, 1, 3, 12, 13, 5, 0);
    access(1, 8'h56, 8'h99);
    access(0, 8'h78, 8'h00);
    set_t(0, 2, 1, 2, 0, 0, 0, 0);
    access(1, 8'h9A, 8'h44);
    // wide offsets at the legal limit, read release window
    set_t(2, 10, 2, 9, 3, 10, 15, 0);
    access(0, 8'hAB, 8'h00);
    access(1, 8'hCD, 8'h21);
    set_t(2, 10, 2, 9, 3, 10, 15, 1);
    access(1, 8'hEF, 8'h77);
    // zero-length cycle
    set_t(0, 0, 0, 0, 0, 0, 15, 0);
    access(0, 8'h01, 8'h00);
    // R7: out-of-range fields
    set_t(0, 11, 1, 3, 0, 4, 15, 0);
    access(0, 8'h02, 8'h00);
    set_t(0, 4, 1, 3, 0, 4, 12, 0);
    access(1, 8'h03, 8'h10);
    set_t(0, 4, 1, 3, 0, 14, 15, 0);
    access(0, 8'h04, 8'h00);
    // R8: ordering errors
    set_t(3, 2, 3, 4, 0, 4, 15, 0);
    access(0, 8'h05, 8'h00);
    set_t(3, 5, 2, 4, 0, 4, 15, 0);
    access(1, 8'h06, 8'h20);
    // R10: start during done cycle, and start while busy
    set_t(0, 4, 1, 3, 0, 4, 15, 0);
    @(negedge clk);
    req_start = 1; req_wr = 1; req_addr = 8'h40; req_wdata = 8'h41;
    @(negedge clk);
    req_start = 0;
    repeat (3) @(negedge clk);
    req_start = 1; req_wr = 0; req_addr = 8'hF0;
    @(negedge clk);
    req_start = 0;
    for (int i = 0; i < 20 && !req_done; i++) @(negedge clk);
    req_start = 1; req_wr = 0; req_addr = 8'h42;
    @(negedge clk);
    req_start = 0;
    repeat (16) @(negedge clk);
    // R11: software reset and clock gate
    sw_reset = 1; clk_enable = 1;
    repeat (4) @(negedge clk);
    sw_reset = 0;
    repeat (3) @(negedge clk);
    clk_enable = 0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule